// File: doc/BRIEF.md
# Dual-Mode Host Bus Front End

This block sits between a host processor bus and the core of a display controller. Two strap inputs pick the bus kind and style. The bus can be a parallel bus with an enable strobe and a read/write level (68-style), a parallel bus with separate active-low read and write strobes (80-style), or a write-only serial link. The serial link borrows the two top data pins as its data and clock.

Whatever the mode, the core sees one stream of byte writes. Each write comes as a single-cycle valid pulse with the byte and a flag that marks it as data or command. Read starts reach the core as one-cycle pulses with the same flag. The block also drives the output half of the 8-bit bidirectional data pins and their output enable. All host pins are brought into the core clock through two-flop synchronizers, so every result trails the pin activity by a fixed number of core clocks.

Top module: `hostbus_frontend`

## Requirements
- R1: While reset is held and right after it, wrValid, rdStrobe and dOe are 0.
- R2: With psSel=1 and m68Sel=0 (80-style), a rise of wrRw while csN is low gives one wrValid pulse. The pulse carries the byte on dIn and wrIsData equal to a0 (1 = data, 0 = command).
- R3: With psSel=1 and m68Sel=1 (68-style), a fall of rdE while wrRw=0 (write) and csN is low gives one wrValid pulse. The pulse carries dIn and a0.
- R4: In 80-style mode, while rdE is low and csN is low, dOe is 1 and dOut equals rdData. One rdStrobe pulse marks the start of the read, with rdIsData equal to a0.
- R5: In 68-style mode, while rdE is high, wrRw is high (read) and csN is low, dOe is 1. One rdStrobe pulse marks the start of the read.
- R6: While csN is high, no strobe activity yields wrValid, rdStrobe or dOe.
- R7: With psSel=0 (serial), bits arrive on dIn[7] and are sampled on each rise of dIn[6], most significant bit first. The eighth rise gives one wrValid pulse with the byte and a0 as sampled at that rise.
- R8: In serial mode, csN high clears the bit count, so a partial byte is dropped.
- R9: In serial mode, rdE and wrRw have no effect, and dOe stays 0.
- R10: Each write and each read start gives exactly one cycle of wrValid or rdStrobe. The two never fire together.
- R11: Each of wrValid, rdStrobe and dOe changes on the third rising clock edge after the pin change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| psSel | input | 1 | Strap: 1 parallel, 0 serial |
| m68Sel | input | 1 | Strap: 1 68-style, 0 80-style |
| csN | input | 1 | Chip select, active low |
| a0 | input | 1 | Transfer kind: 1 data, 0 command |
| rdE | input | 1 | 80-style read strobe (low active) or 68-style enable (high active) |
| wrRw | input | 1 | 80-style write strobe (low active) or 68-style read/write level |
| dIn | input | 8 | Input half of data pins; serial uses bit 7 as data, bit 6 as clock |
| rdData | input | 8 | Read byte from the core |
| dOut | output | 8 | Output half of data pins |
| dOe | output | 1 | Data pin output enable |
| wrValid | output | 1 | One-cycle write pulse |
| wrByte | output | 8 | Written byte, valid with wrValid |
| wrIsData | output | 1 | Data/command flag of the write |
| rdStrobe | output | 1 | One-cycle read start pulse |
| rdIsData | output | 1 | Data/command flag of the read |

## Verification
Every output is due on the third rising edge after the pin change that causes it: two synchronizer flops, then the output register. The bench keeps its own three-deep history of pin samples taken at each rising edge. It derives the expected outputs from the entries two and three edges old, and compares them with the design at each falling edge. For this reason the scenarios hold every pin level for at least three cycles. Scenario-level checks then count and compare the captured writes and read starts against the bytes each scenario sent.

// File: rtl/hif_pkg.sv
package hif_pkg;
  parameter int HIF_DW = 8;

  typedef struct packed {
    logic ps;
    logic m68;
    logic csN;
    logic a0;
    logic rd;
    logic wr;
    logic [HIF_DW-1:0] d;
  } hifPins_t;

  typedef struct packed {
    logic wrPar;
    logic wrSer;
    logic shiftEn;
    logic rdStart;
    logic oeOn;
  } hifStrobes_t;

  localparam hifPins_t HIF_PIN_RST = '{ps: 1'b0, m68: 1'b0, csN: 1'b1, a0: 1'b0,
                                       rd: 1'b0, wr: 1'b0, d: '0};
endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut,
  output logic [W-1:0] syncPrev
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= RST;
        else if (s == 0) stage[s] <= asyncIn;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= RST;
    else syncPrev <= stage[STAGES-1];
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/hif_ctrl.sv
module hif_ctrl
  import hif_pkg::*;
#(
  parameter int DW = HIF_DW
) (
  input  logic        clk,
  input  logic        rstN,
  input  hifPins_t    cur,
  input  hifPins_t    prev,
  output hifStrobes_t stb
);
  localparam int CNTW = $clog2(DW);
  localparam int SCLK_BIT = DW - 2;
  localparam logic [CNTW-1:0] LAST_BIT = CNTW'(DW - 1);

  logic [CNTW-1:0] bitCnt;
  logic readNow, readWas, sclkRise, serialSel;

  function automatic logic readActive(hifPins_t p);
    return p.ps && !p.csN && (p.m68 ? (p.rd && p.wr) : !p.rd);
  endfunction

  always_comb begin
    serialSel = !cur.ps;
    readNow   = readActive(cur);
    readWas   = readActive(prev);
    sclkRise  = cur.d[SCLK_BIT] && !prev.d[SCLK_BIT];

    stb = '0;
    stb.oeOn    = readNow;
    stb.rdStart = readNow && !readWas;
    if (cur.ps && !cur.csN) begin
      if (cur.m68) stb.wrPar = prev.rd && !cur.rd && !cur.wr;
      else         stb.wrPar = !prev.wr && cur.wr;
    end
    stb.shiftEn = serialSel && !cur.csN && sclkRise;
    stb.wrSer   = stb.shiftEn && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (!serialSel || cur.csN) bitCnt <= '0;
    else if (stb.shiftEn) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  end

  // R8: a deselected serial port starts the next byte from bit zero
  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    cur.csN |=> (bitCnt == '0));
endmodule

// File: rtl/hif_dpath.sv
module hif_dpath
  import hif_pkg::*;
#(
  parameter int DW = HIF_DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  hifStrobes_t   stb,
  input  logic [DW-1:0] dCur,
  input  logic          a0Cur,
  input  logic [DW-1:0] rdData,
  output logic [DW-1:0] dOut,
  output logic          dOe,
  output logic          wrValid,
  output logic [DW-1:0] wrByte,
  output logic          wrIsData,
  output logic          rdStrobe,
  output logic          rdIsData
);
  localparam int SDI_BIT = DW - 1;

  logic [DW-1:0] shReg;
  logic [DW-1:0] serByte;

  assign serByte = {shReg[DW-2:0], dCur[SDI_BIT]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      wrValid  <= 1'b0;
      wrByte   <= '0;
      wrIsData <= 1'b0;
      rdStrobe <= 1'b0;
      rdIsData <= 1'b0;
      dOe      <= 1'b0;
    end else begin
      if (stb.shiftEn) shReg <= serByte;
      wrValid  <= stb.wrPar || stb.wrSer;
      if (stb.wrPar || stb.wrSer) begin
        wrByte   <= stb.wrSer ? serByte : dCur;
        wrIsData <= a0Cur;
      end
      rdStrobe <= stb.rdStart;
      if (stb.rdStart) rdIsData <= a0Cur;
      dOe <= stb.oeOn;
    end
  end

  assign dOut = dOe ? rdData : '0;

  assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);
  assert_no_clash_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && rdStrobe));
  assert_rd_drives_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |-> dOe);
endmodule

// File: rtl/hostbus_frontend.sv
module hostbus_frontend
  import hif_pkg::*;
#(
  parameter int DW = HIF_DW,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          psSel,
  input  logic          m68Sel,
  input  logic          csN,
  input  logic          a0,
  input  logic          rdE,
  input  logic          wrRw,
  input  logic [DW-1:0] dIn,
  input  logic [DW-1:0] rdData,
  output logic [DW-1:0] dOut,
  output logic          dOe,
  output logic          wrValid,
  output logic [DW-1:0] wrByte,
  output logic          wrIsData,
  output logic          rdStrobe,
  output logic          rdIsData
);
  localparam int PW = $bits(hifPins_t);

  hifPins_t    pinsIn, pinsCur, pinsPrev;
  hifStrobes_t stb;

  always_comb begin
    pinsIn.ps  = psSel;
    pinsIn.m68 = m68Sel;
    pinsIn.csN = csN;
    pinsIn.a0  = a0;
    pinsIn.rd  = rdE;
    pinsIn.wr  = wrRw;
    pinsIn.d   = dIn;
  end

  hif_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST(HIF_PIN_RST)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pinsIn),
    .syncOut(pinsCur), .syncPrev(pinsPrev)
  );

  hif_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cur(pinsCur), .prev(pinsPrev), .stb(stb)
  );

  hif_dpath #(.DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .dCur(pinsCur.d), .a0Cur(pinsCur.a0),
    .rdData(rdData), .dOut(dOut), .dOe(dOe), .wrValid(wrValid),
    .wrByte(wrByte), .wrIsData(wrIsData), .rdStrobe(rdStrobe),
    .rdIsData(rdIsData)
  );

  // R9: serial mode never turns the data pins around
  assert_serial_no_oe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pinsCur.ps |=> !dOe);
endmodule

// File: tb/hostbus_frontend_bench.sv
module hostbus_frontend_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic psSel = 1'b1, m68Sel = 1'b0, csN = 1'b1, a0 = 1'b0, rdE = 1'b1, wrRw = 1'b1;
  logic [7:0] dIn = 8'h00, rdData = 8'hA5;
  logic [7:0] dOut, wrByte;
  logic dOe, wrValid, wrIsData, rdStrobe, rdIsData;

  int total = 0, bad = 0, cyc = 0;
  string phase = "R1";
  logic [8:0] wrLog[$];
  int rdCount = 0, oeCycles = 0;
  logic [8:0] rdFlag = '0;

  always #2.5 clk = ~clk;

  hostbus_frontend u_hostbus_frontend (
    .clk(clk), .rstN(rstN), .psSel(psSel), .m68Sel(m68Sel), .csN(csN), .a0(a0),
    .rdE(rdE), .wrRw(wrRw), .dIn(dIn), .rdData(rdData), .dOut(dOut), .dOe(dOe),
    .wrValid(wrValid), .wrByte(wrByte), .wrIsData(wrIsData),
    .rdStrobe(rdStrobe), .rdIsData(rdIsData)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: pin samples per rising edge, outputs from 2 and 3 edges back
  typedef struct {
    logic ps, m68, csN, a0, rd, wr;
    logic [7:0] d;
  } samp_t;
  samp_t h1, h2, h3, idleS;
  logic mWr, mWrData, mRd, mRdData, mOe;
  logic [7:0] mWrByte, mSh;
  int mCnt;

  function automatic logic rdOn(samp_t s);
    if (!s.ps || s.csN) return 1'b0;
    if (s.m68) return s.rd && s.wr;
    return !s.rd;
  endfunction

  initial begin
    idleS = '{ps: 0, m68: 0, csN: 1, a0: 0, rd: 0, wr: 0, d: 8'h00};
    h1 = idleS; h2 = idleS; h3 = idleS;
    mWr = 0; mRd = 0; mOe = 0; mWrByte = 0; mWrData = 0; mRdData = 0; mSh = 0; mCnt = 0;
  end

  always @(posedge clk) begin
    samp_t now;
    now = '{ps: psSel, m68: m68Sel, csN: csN, a0: a0, rd: rdE, wr: wrRw, d: dIn};
    if (!rstN) begin
      h1 = idleS; h2 = idleS; h3 = idleS;
      mWr = 0; mRd = 0; mOe = 0; mSh = 0; mCnt = 0; mWrByte = 0; mWrData = 0; mRdData = 0;
    end else begin
      mWr = 0;
      if (h2.ps && !h2.csN) begin
        if (h2.m68 ? (h3.rd && !h2.rd && !h2.wr) : (!h3.wr && h2.wr)) begin
          mWr = 1; mWrByte = h2.d; mWrData = h2.a0;
        end
      end
      if (h2.ps || h2.csN) mCnt = 0;
      else if (!h3.d[6] && h2.d[6]) begin
        mSh = {mSh[6:0], h2.d[7]};
        mCnt++;
        if (mCnt == 8) begin
          mWr = 1; mWrByte = mSh; mWrData = h2.a0; mCnt = 0;
        end
      end
      mOe = rdOn(h2);
      mRd = rdOn(h2) && !rdOn(h3);
      if (mRd) mRdData = h2.a0;
      h3 = h2; h2 = h1; h1 = now;
    end
  end

  // compared at every falling edge (R11 timing covered here)
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      chk({phase, " R11 wrValid"}, 32'(wrValid), 32'(mWr));
      chk({phase, " R11 rdStrobe"}, 32'(rdStrobe), 32'(mRd));
      chk({phase, " R11 dOe"}, 32'(dOe), 32'(mOe));
      if (mWr) chk({phase, " byte"}, {23'd0, wrIsData, wrByte}, {23'd0, mWrData, mWrByte});
      if (mRd) chk({phase, " rdIsData"}, 32'(rdIsData), 32'(mRdData));
      if (mOe) chk({phase, " R4 dOut"}, 32'(dOut), 32'(rdData));
      if (wrValid) wrLog.push_back({wrIsData, wrByte});
      if (rdStrobe) begin rdCount++; rdFlag = {8'd0, rdIsData}; end
      if (dOe) oeCycles++;
    end
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearLog();
    wrLog.delete(); rdCount = 0; oeCycles = 0;
  endtask

  task automatic w80(logic [7:0] b, logic f);
    csN = 0; a0 = f; dIn = b; idle(3);
    wrRw = 0; idle(3); wrRw = 1; idle(4); csN = 1; idle(3);
  endtask

  task automatic w68(logic [7:0] b, logic f);
    csN = 0; a0 = f; dIn = b; wrRw = 0; idle(3);
    rdE = 1; idle(3); rdE = 0; idle(4); wrRw = 1; csN = 1; idle(3);
  endtask

  task automatic sbyte(logic [7:0] b, logic f, int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      dIn[7] = b[i]; dIn[6] = 0; if (i == 0) a0 = f; idle(3);
      dIn[6] = 1; idle(3);
    end
    dIn[6] = 0; idle(3);
  endtask

  initial begin
    idle(4);
    chk("R1 wrValid in reset", 32'(wrValid), 0);
    chk("R1 rdStrobe in reset", 32'(rdStrobe), 0);
    chk("R1 dOe in reset", 32'(dOe), 0);
    rstN = 1; idle(4);
    chk("R1 dOe after reset", 32'(dOe), 0);
    chk("R1 wrValid after reset", 32'(wrValid), 0);

    phase = "R2"; clearLog();
    w80(8'h3C, 1); w80(8'hC1, 0); w80(8'hFF, 1);
    chk("R2 write count", 32'(wrLog.size()), 3);
    if (wrLog.size() == 3) begin
      chk("R2 first", 32'(wrLog[0]), 32'h13C);
      chk("R2 second cmd", 32'(wrLog[1]), 32'h0C1);
      chk("R2 third", 32'(wrLog[2]), 32'h1FF);
    end

    phase = "R4"; clearLog(); rdData = 8'h5A;
    csN = 0; a0 = 1; idle(3); rdE = 0; idle(6); rdE = 1; idle(2); csN = 1; idle(4);
    chk("R4 read starts", 32'(rdCount), 1);
    chk("R4 read flag", 32'(rdFlag), 1);
    chk("R4 oe cycles", 32'(oeCycles), 6);

    phase = "R6"; clearLog();
    csN = 1; wrRw = 0; idle(4); wrRw = 1; idle(4); rdE = 0; idle(4); rdE = 1; idle(4);
    chk("R6 no writes 80", 32'(wrLog.size()), 0);
    chk("R6 no reads 80", 32'(rdCount + oeCycles), 0);

    phase = "R3"; clearLog();
    m68Sel = 1; rdE = 0; wrRw = 1; idle(5);
    w68(8'h81, 0); w68(8'h7E, 1);
    chk("R3 write count", 32'(wrLog.size()), 2);
    if (wrLog.size() == 2) begin
      chk("R3 first", 32'(wrLog[0]), 32'h081);
      chk("R3 second", 32'(wrLog[1]), 32'h17E);
    end

    phase = "R5"; clearLog(); rdData = 8'h96;
    csN = 0; a0 = 0; wrRw = 1; idle(3); rdE = 1; idle(5); rdE = 0; idle(2); csN = 1; idle(4);
    chk("R5 read starts", 32'(rdCount), 1);
    chk("R5 read flag cmd", 32'(rdFlag), 0);
    chk("R5 oe cycles", 32'(oeCycles), 5);
    chk("R5 no write", 32'(wrLog.size()), 0);

    phase = "R6"; clearLog();
    rdE = 1; idle(4); rdE = 0; wrRw = 0; idle(4); rdE = 1; idle(4); rdE = 0; wrRw = 1; idle(4);
    chk("R6 no activity 68", 32'(wrLog.size() + rdCount + oeCycles), 0);

    phase = "R7"; clearLog();
    psSel = 0; m68Sel = 0; rdE = 1; wrRw = 1; dIn = 8'h00; idle(5);
    csN = 0; idle(3);
    sbyte(8'hB2, 1, 8); sbyte(8'h4D, 0, 8);
    csN = 1; idle(4);
    chk("R7 serial count", 32'(wrLog.size()), 2);
    if (wrLog.size() == 2) begin
      chk("R7 first", 32'(wrLog[0]), 32'h1B2);
      chk("R7 second", 32'(wrLog[1]), 32'h04D);
    end

    phase = "R8"; clearLog();
    csN = 0; idle(3); sbyte(8'hE0, 0, 3); csN = 1; idle(4);
    csN = 0; idle(3); sbyte(8'h3C, 1, 8); csN = 1; idle(4);
    chk("R8 count after abort", 32'(wrLog.size()), 1);
    if (wrLog.size() == 1) chk("R8 byte after abort", 32'(wrLog[0]), 32'h13C);

    phase = "R9"; clearLog();
    csN = 0; a0 = 1; idle(3);
    rdE = 0; idle(5); wrRw = 0; idle(5); wrRw = 1; idle(5); rdE = 1; idle(5);
    csN = 1; idle(4);
    chk("R9 no serial writes", 32'(wrLog.size()), 0);
    chk("R9 no reads or oe", 32'(rdCount + oeCycles), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule